// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two IEEE-754 binary floating-point operands and reports the outcome as a four-bit condition code together with an invalid-operation indication. It is purely combinational: the result follows the operands in the same cycle, so it can sit directly between an operand read stage and a flag-writing stage of an execution pipeline.

A two-bit format select picks half, single or double precision. Operands always arrive right-aligned in 64-bit inputs, and any bits above the selected width are ignored. A mode input chooses between the quiet compare, which complains only about signalling NaNs, and the signalling compare, which complains about any NaN. Internally each operand is unpacked for all three formats at once, the selected set is ordered into one of four relations (less, equal, greater, unordered), and that relation is mapped to the flag word.

The block has no storage, so it has no state machine and no state names. The four relations act as its only named outcomes: LESS, EQUAL, GREATER and UNORDERED.

Top module: `fpcmp_flags`

## Requirements
- R1: When the operands are ordered and equal, the flag output is 4'b0110 (bit 3 N=0, bit 2 Z=1, bit 1 C=1, bit 0 V=0).
- R2: When operand A is ordered and less than operand B, the flag output is 4'b1000 (only N set).
- R3: When operand A is ordered and greater than operand B, the flag output is 4'b0010 (only C set).
- R4: When either operand is a NaN (exponent all ones, fraction nonzero), the result is unordered and the flag output is 4'b0011 (C and V set, N and Z clear).
- R5: Format select 2'd0 uses bits 15:0 (5-bit exponent, 10-bit fraction), 2'd1 uses bits 31:0 (8-bit exponent, 23-bit fraction), 2'd2 and 2'd3 use all 64 bits (11-bit exponent, 52-bit fraction); bits above the selected width have no effect on either output.
- R6: Positive zero and negative zero compare equal in every order.
- R7: Non-NaN values are ordered by sign and magnitude: any positive value is greater than any negative one except for the zero pair, a larger magnitude is greater between two positives and smaller between two negatives, and infinities are the extremes.
- R8: With the mode input at 0 (quiet compare), the invalid output is 1 exactly when at least one operand is a signalling NaN (NaN whose fraction MSB is 0).
- R9: With the mode input at 1 (signalling compare), the invalid output is 1 exactly when at least one operand is a NaN of either kind.
- R10: The invalid output is 0 whenever neither operand is a NaN, in both modes, including for infinities and zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fmt_sel | input | 2 | Precision: 0 half, 1 single, 2 or 3 double |
| signal_mode | input | 1 | 0 quiet compare, 1 signalling compare |
| op_a | input | 64 | First operand, right-aligned |
| op_b | input | 64 | Second operand, right-aligned |
| nzcv | output | 4 | Condition flags packed {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation indication |

## Verification
Directed pairs probe each relation with small normal values, then the sign handling with mixed signs, two negatives and the signed zero pair, which separates a correct sign-magnitude ordering from a plain unsigned or two's-complement compare of the bit patterns. Quiet and signalling NaNs are each paired with ordinary numbers under both modes, which tells the two invalid rules apart, while infinities under the signalling mode show that the all-ones exponent alone does not raise invalid. Garbage placed above a narrow operand shows whether the format select really masks the unused bits. A sweep then pairs ten class representatives (both zeros, plus and minus one, both infinities, both NaN kinds, largest finite, smallest denormal) in every order, in all formats and both modes, against a bench model that orders values through a signed integer key rather than by sign and magnitude.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int WORD_W = 64;
    localparam int MAG_W  = WORD_W - 1;
    localparam int NUM_FMT = 3;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2
    } fpc_fmt_e;

    typedef enum logic [1:0] {
        REL_LESS      = 2'd0,
        REL_EQUAL     = 2'd1,
        REL_GREATER   = 2'd2,
        REL_UNORDERED = 2'd3
    } fpc_rel_e;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_zero;
        logic [MAG_W-1:0] mag;
    } fpc_opnd_t;

    function automatic int exp_width(input int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int frac_width(input int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/fpc_unpack.sv
module fpc_unpack
    import fpc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int TOT_W = 1 + EXP_W + FRAC_W
) (
    input  logic [TOT_W-1:0] word,
    output fpc_opnd_t        opnd,
    output logic             is_snan
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              frac_nz;

    always_comb begin
        exp_f   = word[TOT_W-2:FRAC_W];
        frac_f  = word[FRAC_W-1:0];
        exp_max = &exp_f;
        frac_nz = |frac_f;

        opnd.sign    = word[TOT_W-1];
        opnd.is_nan  = exp_max && frac_nz;
        opnd.is_zero = !(|exp_f) && !frac_nz;
        opnd.mag     = '0;
        opnd.mag[TOT_W-2:0] = word[TOT_W-2:0];

        is_snan = exp_max && frac_nz && !frac_f[FRAC_W-1];
    end

    always_comb begin
        if (!$isunknown(word)) begin
            AST_SNAN_IS_NAN: assert (!is_snan || opnd.is_nan); // R8
        end
    end

endmodule

// File: rtl/fpc_relate.sv
module fpc_relate
    import fpc_pkg::*;
(
    input  fpc_opnd_t opa,
    input  fpc_opnd_t opb,
    output fpc_rel_e  rel
);

    logic mag_gt;
    logic mag_eq;

    always_comb begin
        mag_gt = opa.mag > opb.mag;
        mag_eq = opa.mag == opb.mag;
        if (opa.is_nan || opb.is_nan) begin
            rel = REL_UNORDERED;
        end else if (opa.is_zero && opb.is_zero) begin
            rel = REL_EQUAL;
        end else if (opa.sign != opb.sign) begin
            rel = opa.sign ? REL_LESS : REL_GREATER;
        end else if (mag_eq) begin
            rel = REL_EQUAL;
        end else if (mag_gt ^ opa.sign) begin
            rel = REL_GREATER;
        end else begin
            rel = REL_LESS;
        end
    end

    always_comb begin
        if (!$isunknown({opa, opb})) begin
            AST_ZERO_PAIR_EQUAL: assert (!(opa.is_zero && opb.is_zero) || rel == REL_EQUAL); // R6
            AST_POS_ABOVE_NEG: assert (!(!opa.is_nan && !opb.is_nan && !opa.sign && opb.sign
                                         && !(opa.is_zero && opb.is_zero)) || rel == REL_GREATER); // R7
        end
    end

endmodule

// File: rtl/fpc_flags.sv
module fpc_flags
    import fpc_pkg::*;
(
    input  fpc_rel_e   rel,
    input  logic       signal_mode,
    input  logic       a_nan,
    input  logic       b_nan,
    input  logic       a_snan,
    input  logic       b_snan,
    output logic [3:0] nzcv,
    output logic       invalid
);

    always_comb begin
        unique case (rel)
            REL_EQUAL:     nzcv = 4'b0110;
            REL_LESS:      nzcv = 4'b1000;
            REL_GREATER:   nzcv = 4'b0010;
            REL_UNORDERED: nzcv = 4'b0011;
            default:       nzcv = 4'b0011;
        endcase
        if (signal_mode) begin
            invalid = a_nan || b_nan;
        end else begin
            invalid = a_snan || b_snan;
        end
    end

    always_comb begin
        if (!$isunknown({rel, signal_mode, a_nan, b_nan, a_snan, b_snan})) begin
            AST_UNORDERED_FLAGS: assert (!(a_nan || b_nan) || nzcv == 4'b0011); // R4
            AST_NAN_NEEDED: assert (!invalid || a_nan || b_nan); // R10
            AST_SNAN_RAISES: assert (!(a_snan || b_snan) || invalid); // R8
            AST_ONE_RELATION: assert ($countones(nzcv) == 1 || nzcv == 4'b0110 || nzcv == 4'b0011); // R1
        end
    end

endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
    import fpc_pkg::*;
(
    input  logic [1:0]  fmt_sel,
    input  logic        signal_mode,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    output logic [3:0]  nzcv,
    output logic        invalid
);

    fpc_opnd_t ua   [NUM_FMT];
    fpc_opnd_t ub   [NUM_FMT];
    logic      sa   [NUM_FMT];
    logic      sb   [NUM_FMT];

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int EW = exp_width(g);
        localparam int FW = frac_width(g);
        localparam int TW = 1 + EW + FW;

        fpc_unpack #(.EXP_W(EW), .FRAC_W(FW)) u_unpack_a (
            .word    (op_a[TW-1:0]),
            .opnd    (ua[g]),
            .is_snan (sa[g])
        );

        fpc_unpack #(.EXP_W(EW), .FRAC_W(FW)) u_unpack_b (
            .word    (op_b[TW-1:0]),
            .opnd    (ub[g]),
            .is_snan (sb[g])
        );
    end

    fpc_opnd_t sel_a;
    fpc_opnd_t sel_b;
    logic      sel_sa;
    logic      sel_sb;
    fpc_rel_e  rel;

    always_comb begin
        unique case (fmt_sel)
            FMT_HALF: begin
                sel_a = ua[0]; sel_b = ub[0]; sel_sa = sa[0]; sel_sb = sb[0];
            end
            FMT_SINGLE: begin
                sel_a = ua[1]; sel_b = ub[1]; sel_sa = sa[1]; sel_sb = sb[1];
            end
            default: begin
                sel_a = ua[2]; sel_b = ub[2]; sel_sa = sa[2]; sel_sb = sb[2];
            end
        endcase
    end

    fpc_relate u_relate (
        .opa (sel_a),
        .opb (sel_b),
        .rel (rel)
    );

    fpc_flags u_flags (
        .rel         (rel),
        .signal_mode (signal_mode),
        .a_nan       (sel_a.is_nan),
        .b_nan       (sel_b.is_nan),
        .a_snan      (sel_sa),
        .b_snan      (sel_sb),
        .nzcv        (nzcv),
        .invalid     (invalid)
    );

    always_comb begin
        if (!$isunknown({fmt_sel, signal_mode, op_a, op_b})) begin
            AST_SIGNAL_MODE_NAN: assert (!(signal_mode && (sel_a.is_nan || sel_b.is_nan)) || invalid); // R9
        end
    end

endmodule

// File: tb/test_fpcmp_flags.sv
module test_fpcmp_flags;

    logic        clk = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic        signal_mode = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  nzcv;
    logic        invalid;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #2 clk = ~clk;

    fpcmp_flags i_fpcmp_flags (
        .fmt_sel     (fmt_sel),
        .signal_mode (signal_mode),
        .op_a        (op_a),
        .op_b        (op_b),
        .nzcv        (nzcv),
        .invalid     (invalid)
    );

    localparam logic [3:0] F_EQ = 4'b0110;
    localparam logic [3:0] F_LT = 4'b1000;
    localparam logic [3:0] F_GT = 4'b0010;
    localparam logic [3:0] F_UN = 4'b0011;

    task automatic apply(input logic [1:0] f, input logic m,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        fmt_sel = f; signal_mode = m; op_a = a; op_b = b;
        #1;
    endtask

    task automatic check(input string tag, input logic [3:0] exp_f, input logic exp_i);
        n_tests++;
        if (nzcv !== exp_f || invalid !== exp_i) begin
            n_fail++;
            $display("FAIL %s: fmt=%0d mode=%0b a=%h b=%h got nzcv=%b inv=%b expected nzcv=%b inv=%b",
                     tag, fmt_sel, signal_mode, op_a, op_b, nzcv, invalid, exp_f, exp_i);
        end
    endtask

    function automatic int ew_of(input int f);
        return (f == 0) ? 5 : (f == 1) ? 8 : 11;
    endfunction

    function automatic int fw_of(input int f);
        return (f == 0) ? 10 : (f == 1) ? 23 : 52;
    endfunction

    function automatic logic [63:0] pat(input int f, input int k);
        int ew, fw, tot;
        logic [63:0] sgn, expall, one;
        ew = ew_of(f); fw = fw_of(f); tot = 1 + ew + fw;
        sgn    = 64'd1 << (tot - 1);
        expall = ((64'd1 << ew) - 64'd1) << fw;
        one    = ((64'd1 << (ew - 1)) - 64'd1) << fw;
        case (k)
            0: return 64'd0;
            1: return sgn;
            2: return one;
            3: return sgn | one;
            4: return expall;
            5: return sgn | expall;
            6: return expall | (64'd1 << (fw - 1));
            7: return expall | 64'd1;
            8: return expall - 64'd1;
            default: return 64'd1;
        endcase
    endfunction

    function automatic logic [4:0] ref_cmp(input int f, input logic m,
                                           input logic [63:0] a, input logic [63:0] b);
        int ew, fw, tot;
        logic [63:0] msk, wa, wb, ea, eb, fa, fb, magmask;
        logic na, nb, qa, qb, inv;
        logic signed [64:0] ka, kb;
        logic [3:0] fl;
        ew = ew_of(f); fw = fw_of(f); tot = 1 + ew + fw;
        msk = (tot == 64) ? '1 : ((64'd1 << tot) - 64'd1);
        magmask = msk >> 1;
        wa = a & msk; wb = b & msk;
        ea = (wa >> fw) & ((64'd1 << ew) - 64'd1);
        eb = (wb >> fw) & ((64'd1 << ew) - 64'd1);
        fa = wa & ((64'd1 << fw) - 64'd1);
        fb = wb & ((64'd1 << fw) - 64'd1);
        na = (ea == ((64'd1 << ew) - 64'd1)) && (fa != 0);
        nb = (eb == ((64'd1 << ew) - 64'd1)) && (fb != 0);
        qa = fa[fw-1]; qb = fb[fw-1];
        ka = {1'b0, wa & magmask};
        kb = {1'b0, wb & magmask};
        if (wa[tot-1]) ka = -ka;
        if (wb[tot-1]) kb = -kb;
        if (na || nb)       fl = F_UN;
        else if (ka == kb)  fl = F_EQ;
        else if (ka < kb)   fl = F_LT;
        else                fl = F_GT;
        if (m) inv = na || nb;
        else   inv = (na && !qa) || (nb && !qb);
        return {fl, inv};
    endfunction

    task automatic t_idle();
        #1;
        check("R1 idle all-zero inputs", F_EQ, 1'b0);
    endtask

    task automatic t_equal();
        apply(2'd0, 1'b0, 64'h3C00, 64'h3C00);
        check("R1 half 1.0==1.0", F_EQ, 1'b0);
        apply(2'd2, 1'b1, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000);
        check("R1 double 1.0==1.0", F_EQ, 1'b0);
    endtask

    task automatic t_less();
        apply(2'd1, 1'b0, 64'h3F80_0000, 64'h4000_0000);
        check("R2 single 1.0<2.0", F_LT, 1'b0);
    endtask

    task automatic t_greater();
        apply(2'd2, 1'b0, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000);
        check("R3 double 2.0>1.0", F_GT, 1'b0);
    endtask

    task automatic t_unordered();
        apply(2'd1, 1'b0, 64'h7FC0_0000, 64'h3F80_0000);
        check("R4 single qNaN vs 1.0", F_UN, 1'b0);
        apply(2'd2, 1'b0, 64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_0000);
        check("R4 double 1.0 vs qNaN", F_UN, 1'b0);
    endtask

    task automatic t_format();
        apply(2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_3C00, 64'h1234_5678_0000_4000);
        check("R5 half ignores upper bits", F_LT, 1'b0);
        apply(2'd1, 1'b1, 64'h7FF8_0000_3F80_0000, 64'h0000_0000_3F80_0000);
        check("R5 single ignores upper NaN pattern", F_EQ, 1'b0);
        apply(2'd3, 1'b0, 64'hBFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000);
        check("R5 select 3 acts as double", F_LT, 1'b0);
    endtask

    task automatic t_zero();
        apply(2'd0, 1'b0, 64'h8000, 64'h0000);
        check("R6 half -0 vs +0", F_EQ, 1'b0);
        apply(2'd2, 1'b1, 64'h0, 64'h8000_0000_0000_0000);
        check("R6 double +0 vs -0", F_EQ, 1'b0);
    endtask

    task automatic t_order();
        apply(2'd1, 1'b0, 64'hC000_0000, 64'hBF80_0000);
        check("R7 single -2.0<-1.0", F_LT, 1'b0);
        apply(2'd1, 1'b0, 64'hBF80_0000, 64'h3F80_0000);
        check("R7 single -1.0<+1.0", F_LT, 1'b0);
        apply(2'd0, 1'b0, 64'h7C00, 64'h7BFF);
        check("R7 half +inf>max finite", F_GT, 1'b0);
        apply(2'd0, 1'b0, 64'hFC00, 64'hFBFF);
        check("R7 half -inf<-max finite", F_LT, 1'b0);
    endtask

    task automatic t_quiet_inv();
        apply(2'd0, 1'b0, 64'h7C01, 64'h3C00);
        check("R8 quiet mode sNaN raises", F_UN, 1'b1);
        apply(2'd0, 1'b0, 64'h3C00, 64'h7E00);
        check("R8 quiet mode qNaN silent", F_UN, 1'b0);
    endtask

    task automatic t_signal_inv();
        apply(2'd1, 1'b1, 64'h7FC0_0000, 64'h3F80_0000);
        check("R9 signalling mode qNaN raises", F_UN, 1'b1);
        apply(2'd2, 1'b1, 64'h3FF0_0000_0000_0000, 64'hFFF0_0000_0000_0001);
        check("R9 signalling mode sNaN raises", F_UN, 1'b1);
    endtask

    task automatic t_no_inv();
        apply(2'd2, 1'b1, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000);
        check("R10 +inf==+inf no invalid", F_EQ, 1'b0);
        apply(2'd0, 1'b1, 64'hFC00, 64'h8000);
        check("R10 -inf<-0 no invalid", F_LT, 1'b0);
    endtask

    task automatic t_sweep();
        logic [4:0] r;
        for (int f = 0; f < 3; f++) begin
            for (int m = 0; m < 2; m++) begin
                for (int i = 0; i < 10; i++) begin
                    for (int j = 0; j < 10; j++) begin
                        apply(2'(f), 1'(m), pat(f, i), pat(f, j));
                        r = ref_cmp(f, 1'(m), pat(f, i), pat(f, j));
                        check("R7 R8 R9 sweep vs model", r[4:1], r[0]);
                    end
                end
            end
        end
    endtask

    initial begin
        t_idle();
        t_equal();
        t_less();
        t_greater();
        t_unordered();
        t_format();
        t_zero();
        t_order();
        t_quiet_inv();
        t_signal_inv();
        t_no_inv();
        t_sweep();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule